// File: doc/BRIEF.md
# Byte and Word Burst FIFO Register Port

This block is the register-mapped front end that sits between a host bus and the receive and transmit byte queues of a serial port. Software can move one byte per access through the shared data offset. It can also move four bytes per 32-bit access through two separate burst windows, one for each direction. A single packed status word reports both queue levels, a "nothing pending" indication and the receive line-status flags. An interrupt request is raised whenever received data or an error condition needs attention.

On the line side, a receiver pushes one byte per cycle, with its parity and framing flags. A transmitter takes bytes from the head of the transmit queue with a valid/ready pair. Burst words are packed little-endian, so the oldest byte sits in bits 7:0. A burst that cannot be fully served moves only the bytes that are available and raises a sticky access-error flag. A burst that cannot be fully served is a read with fewer than four bytes queued, or a write with fewer than four free entries. The overrun flag is cleared only by writing the code 0x43 to the queue-control offset.

Top module: `burst_fifo_port`

## Requirements
- R1: A write to offset 0x00 appends bits 7:0 of the write data to the transmit queue. The transmitter receives bytes in the order they were written, through `txValid`/`txData`/`txReady`.
- R2: A read at offset 0x00 returns the oldest received byte in bits 7:0, with the upper bits zero, and removes that byte from the receive queue.
- R3: A write to offset 0xA0 appends four bytes to the transmit queue. Bits 7:0 are queued first, then 15:8, then 23:16, then 31:24.
- R4: A read at offset 0xA4 returns the four oldest received bytes, the oldest in bits 7:0, and removes all four.
- R5: A read at offset 0x9C returns the receive byte count in bits 7:0 and the free transmit entries in bits 15:8.
- R6: A burst read with fewer than four bytes queued moves only the queued bytes and returns zero in the unused byte lanes. A burst write with fewer than four free entries queues only the leading bytes that fit. Either case sets the access-error flag, status bit 16.
- R7: A byte that arrives while the receive queue is full is dropped and sets the overrun flag, status bit 25. Only a write of 0x43 to offset 0x02 clears the overrun flag and the access-error flag; writing any other value there has no effect.
- R8: A received byte accepted with its parity flag sets status bit 26. One accepted with its framing flag sets status bit 27. Both flags clear on a read of the status word, unless a new error arrives in the same cycle.
- R9: Status bit 20 is 1 exactly when no interrupt is pending, and `irqOut` is its inverse. An interrupt is pending while the receive queue is non-empty or any of the overrun, parity or framing flags is set.
- R10: Status bit 24 is 1 when the receive queue is non-empty. Status bit 29 is 1 when the transmit queue is empty. Status bits 23:21, 19:17, 28, 30 and 31 read as zero.
- R11: A byte write to a full transmit queue is dropped, and a byte read of an empty receive queue returns zero. Both set the access-error flag and leave the queues unchanged.
- R12: After reset both queues are empty and every flag is clear. With the default depth of 16, the status word reads 0x20101000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe; read side effects take place at the clock edge |
| regAddr | input | ADDR_W | Byte offset of the access |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from the current state while `regRd` is high |
| rxValid | input | 1 | Receiver presents a byte this cycle |
| rxData | input | 8 | Received byte |
| rxParityErr | input | 1 | Parity error flag for the received byte |
| rxFrameErr | input | 1 | Framing error flag for the received byte |
| txValid | output | 1 | Transmit queue holds a byte |
| txData | output | 8 | Oldest transmit byte |
| txReady | input | 1 | Transmitter takes the head byte |
| irqOut | output | 1 | Interrupt request |

## Verification
The assertions assume that the host never asks a queue to move more bytes than it holds or has room for. The control logic guarantees this by clamping every transfer to the pre-edge levels. The queue checks therefore watch the requested push and pop counts against the level. The flag checks assume that the receive side presents at most one byte per cycle. The stimulus is shaped deliberately to keep within those assumptions while pressing the edges. It drives a full transmit queue against burst and byte writes. It pushes into a full receive queue while the host pops in the same cycle. It also mixes status reads with new line errors in a single cycle.

// File: rtl/burst_fifo_pkg.sv
package burst_fifo_pkg;

  localparam int OFS_DATA    = 8'h00;
  localparam int OFS_QCTL    = 8'h02;
  localparam int OFS_STATUS  = 8'h9C;
  localparam int OFS_TXBURST = 8'hA0;
  localparam int OFS_RXBURST = 8'hA4;
  localparam logic [7:0] CLEAR_CODE = 8'h43;

  localparam int BURST_BYTES = 4;
  localparam int LANE_W      = 3;

  // status word bit positions
  localparam int ST_ACCERR  = 16;
  localparam int ST_NOIRQ   = 20;
  localparam int ST_RDY     = 24;
  localparam int ST_OVR     = 25;
  localparam int ST_PAR     = 26;
  localparam int ST_FRM     = 27;
  localparam int ST_TXEMPTY = 29;

  typedef struct packed {
    logic txByte;
    logic txBurst;
    logic rxByte;
    logic rxBurst;
    logic statRead;
    logic clrFlags;
  } busStrobes_t;

endpackage

// File: rtl/burst_byte_queue.sv
module burst_byte_queue #(
  parameter int DEPTH       = 16,
  parameter int PUSH_BYTES  = 4,
  parameter int HEAD_BYTES  = 4,
  localparam int PTR_W      = $clog2(DEPTH),
  localparam int CNT_W      = PTR_W + 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2:0]              pushN,
  input  logic [8*PUSH_BYTES-1:0] pushData,
  input  logic [2:0]              popN,
  output logic [8*HEAD_BYTES-1:0] headData,
  output logic [CNT_W-1:0]        count
);

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;

  always_ff @(posedge clk) begin
    for (int k = 0; k < PUSH_BYTES; k++) begin
      if (3'(k) < pushN) mem[wrPtr + PTR_W'(k)] <= pushData[8*k +: 8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      wrPtr <= wrPtr + PTR_W'(pushN);
      rdPtr <= rdPtr + PTR_W'(popN);
      count <= count + CNT_W'(pushN) - CNT_W'(popN);
    end
  end

  for (genvar g = 0; g < HEAD_BYTES; g++) begin : g_head
    assign headData[8*g +: 8] = mem[rdPtr + PTR_W'(g)];
  end

  // R5: level never exceeds the depth
  p_level_bound_r5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  // R6: a push never asks for more room than is free
  p_push_fits_r6: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(pushN) <= CNT_W'(DEPTH) - count);
  // R6: a pop never asks for more bytes than are held
  p_pop_fits_r6: assert property (@(posedge clk) disable iff (!rstN)
    CNT_W'(popN) <= count);

endmodule

// File: rtl/burst_port_ctrl.sv
module burst_port_ctrl
  import burst_fifo_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWrByte,
  output busStrobes_t       strobes
);

  logic hitData, hitCtl, hitStat, hitTxB, hitRxB;

  always_comb begin
    hitData = (regAddr == ADDR_W'(OFS_DATA));
    hitCtl  = (regAddr == ADDR_W'(OFS_QCTL));
    hitStat = (regAddr == ADDR_W'(OFS_STATUS));
    hitTxB  = (regAddr == ADDR_W'(OFS_TXBURST));
    hitRxB  = (regAddr == ADDR_W'(OFS_RXBURST));

    strobes.txByte   = regWr && hitData;
    strobes.txBurst  = regWr && hitTxB;
    strobes.clrFlags = regWr && hitCtl && (regWrByte == CLEAR_CODE);
    strobes.rxByte   = regRd && hitData;
    strobes.rxBurst  = regRd && hitRxB;
    strobes.statRead = regRd && hitStat;
  end

endmodule

// File: rtl/burst_port_datapath.sv
module burst_port_datapath
  import burst_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  busStrobes_t strobes,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        rxValid,
  input  logic [7:0]  rxData,
  input  logic        rxParityErr,
  input  logic        rxFrameErr,
  output logic        txValid,
  output logic [7:0]  txData,
  input  logic        txReady,
  output logic        irqOut
);

  localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] BURST = CNT_W'(BURST_BYTES);

  logic [CNT_W-1:0] rxCount, txCount, txFree;
  logic [31:0]      rxHead;
  logic [7:0]       txHead;
  logic [2:0]       rxPopN, rxPushN, txPushN, txPopN;
  logic             rxAccept, shortAccess, pending;
  logic             overrun, parityFlag, frameFlag, accessErr;
  logic [31:0]      statusWord, popWord;

  burst_byte_queue #(.DEPTH(DEPTH), .PUSH_BYTES(1), .HEAD_BYTES(BURST_BYTES)) rxQ (
    .clk(clk), .rstN(rstN), .pushN(rxPushN), .pushData(rxData),
    .popN(rxPopN), .headData(rxHead), .count(rxCount));

  burst_byte_queue #(.DEPTH(DEPTH), .PUSH_BYTES(BURST_BYTES), .HEAD_BYTES(1)) txQ (
    .clk(clk), .rstN(rstN), .pushN(txPushN), .pushData(regWrData),
    .popN(txPopN), .headData(txHead), .count(txCount));

  always_comb begin
    txFree   = FULL - txCount;
    rxAccept = rxValid && (rxCount != FULL);
    rxPushN  = rxAccept ? 3'd1 : 3'd0;
    txPopN   = (txReady && txCount != '0) ? 3'd1 : 3'd0;

    rxPopN = 3'd0;
    if (strobes.rxByte)
      rxPopN = (rxCount != '0) ? 3'd1 : 3'd0;
    else if (strobes.rxBurst)
      rxPopN = (rxCount >= BURST) ? 3'(BURST_BYTES) : 3'(rxCount);

    txPushN = 3'd0;
    if (strobes.txByte)
      txPushN = (txFree != '0) ? 3'd1 : 3'd0;
    else if (strobes.txBurst)
      txPushN = (txFree >= BURST) ? 3'(BURST_BYTES) : 3'(txFree);

    shortAccess = (strobes.rxByte  && rxCount == '0)
               || (strobes.rxBurst && rxCount <  BURST)
               || (strobes.txByte  && txFree  == '0)
               || (strobes.txBurst && txFree  <  BURST);
  end

  // lanes beyond the moved byte count read as zero
  for (genvar g = 0; g < BURST_BYTES; g++) begin : g_lane
    assign popWord[8*g +: 8] = (3'(g) < rxPopN) ? rxHead[8*g +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overrun    <= 1'b0;
      parityFlag <= 1'b0;
      frameFlag  <= 1'b0;
      accessErr  <= 1'b0;
    end else begin
      overrun    <= (rxValid && !rxAccept) || (overrun && !strobes.clrFlags);
      accessErr  <= shortAccess || (accessErr && !strobes.clrFlags);
      parityFlag <= (rxAccept && rxParityErr) || (parityFlag && !strobes.statRead);
      frameFlag  <= (rxAccept && rxFrameErr)  || (frameFlag  && !strobes.statRead);
    end
  end

  always_comb begin
    pending                = (rxCount != '0) || overrun || parityFlag || frameFlag;
    statusWord             = '0;
    statusWord[7:0]        = 8'(rxCount);
    statusWord[15:8]       = 8'(txFree);
    statusWord[ST_ACCERR]  = accessErr;
    statusWord[ST_NOIRQ]   = !pending;
    statusWord[ST_RDY]     = (rxCount != '0);
    statusWord[ST_OVR]     = overrun;
    statusWord[ST_PAR]     = parityFlag;
    statusWord[ST_FRM]     = frameFlag;
    statusWord[ST_TXEMPTY] = (txCount == '0);

    if (strobes.rxByte || strobes.rxBurst) regRdData = popWord;
    else if (strobes.statRead)             regRdData = statusWord;
    else                                   regRdData = '0;
  end

  assign txValid = (txCount != '0);
  assign txData  = txHead;
  assign irqOut  = pending;

  // R7: overrun holds until the clear code is written
  p_overrun_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !strobes.clrFlags |=> overrun);
  // R7: a byte arriving at a full receive queue raises overrun
  p_overrun_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && rxCount == FULL |=> overrun);
  // R6: a short access leaves the access-error flag set
  p_short_flag_r6: assert property (@(posedge clk) disable iff (!rstN)
    shortAccess |=> accessErr);
  // R9: queued receive data always requests an interrupt
  p_irq_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    rxCount != '0 |-> irqOut);

endmodule

// File: rtl/burst_fifo_port.sv
module burst_fifo_port
  import burst_fifo_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              rxValid,
  input  logic [7:0]        rxData,
  input  logic              rxParityErr,
  input  logic              rxFrameErr,
  output logic              txValid,
  output logic [7:0]        txData,
  input  logic              txReady,
  output logic              irqOut
);

  busStrobes_t strobes;

  burst_port_ctrl #(.ADDR_W(ADDR_W)) ctrl (
    .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrByte(regWrData[7:0]), .strobes(strobes));

  burst_port_datapath #(.DEPTH(DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .regWrData(regWrData), .regRdData(regRdData),
    .rxValid(rxValid), .rxData(rxData),
    .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .txValid(txValid), .txData(txData), .txReady(txReady),
    .irqOut(irqOut));

endmodule

// File: tb/tb_burst_fifo_port.sv
`timescale 1ns/1ps
module tb_burst_fifo_port;

  localparam int D = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 0, regRd = 0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic rxValid = 0, rxParityErr = 0, rxFrameErr = 0, txReady = 0;
  logic [7:0] rxData = '0;
  logic txValid, irqOut;
  logic [7:0] txData;

  int tests = 0;
  int fails = 0;

  // reference state
  byte unsigned rxq[$];
  byte unsigned txq[$];
  bit mOvr, mPar, mFrm, mErr;

  always #2.5 clk = ~clk;

  burst_fifo_port dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .rxValid(rxValid),
    .rxData(rxData), .rxParityErr(rxParityErr), .rxFrameErr(rxFrameErr),
    .txValid(txValid), .txData(txData), .txReady(txReady), .irqOut(irqOut));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelStatus();
    logic [31:0] s = '0;
    bit pend = (rxq.size() != 0) || mOvr || mPar || mFrm;
    s[7:0]  = 8'(rxq.size());
    s[15:8] = 8'(D - txq.size());
    s[16] = mErr; s[20] = !pend; s[24] = (rxq.size() != 0);
    s[25] = mOvr; s[26] = mPar; s[27] = mFrm; s[29] = (txq.size() == 0);
    return s;
  endfunction

  // one bus/line cycle: drive, check read data, update model, clock, compare
  task automatic cyc(input bit wr, input bit rd, input logic [7:0] a,
                     input logic [31:0] wd, input bit rv, input logic [7:0] rb,
                     input bit pe, input bit fe, input bit tr, input string tag);
    int preRx = rxq.size();
    int preTx = txq.size();
    bit setO = 0, setE = 0, clrE = 0, clrPF = 0, setP = 0, setF = 0;
    logic [31:0] exp = '0;
    int n;
    regWr = wr; regRd = rd; regAddr = a; regWrData = wd;
    rxValid = rv; rxData = rb; rxParityErr = pe; rxFrameErr = fe; txReady = tr;
    #1;
    if (rd) begin
      if (a == 8'h00) begin
        if (preRx > 0) exp[7:0] = rxq[0];
        else setE = 1;
        if (preRx > 0) void'(rxq.pop_front());
      end else if (a == 8'hA4) begin
        n = (preRx >= 4) ? 4 : preRx;
        if (n < 4) setE = 1;
        for (int k = 0; k < n; k++) exp[8*k +: 8] = rxq.pop_front();
      end else if (a == 8'h9C) begin
        exp = modelStatus();
        clrPF = 1;
      end
      check(tag, regRdData, exp);
    end
    if (tr && preTx > 0) void'(txq.pop_front());
    if (wr) begin
      if (a == 8'h00) begin
        if (preTx < D) txq.push_back(wd[7:0]);
        else setE = 1;
      end else if (a == 8'hA0) begin
        n = (D - preTx >= 4) ? 4 : D - preTx;
        if (n < 4) setE = 1;
        for (int k = 0; k < n; k++) txq.push_back(wd[8*k +: 8]);
      end else if (a == 8'h02 && wd[7:0] == 8'h43) begin
        clrE = 1;
      end
    end
    if (rv) begin
      if (preRx < D) begin rxq.push_back(rb); setP = pe; setF = fe; end
      else setO = 1;
    end
    mOvr = setO || (mOvr && !clrE);
    mErr = setE || (mErr && !clrE);
    mPar = setP || (mPar && !clrPF);
    mFrm = setF || (mFrm && !clrPF);
    @(posedge clk);
    #1;
    regWr = 0; regRd = 0; rxValid = 0; txReady = 0;
    check({tag, " R1 txValid"}, 32'(txValid), 32'(txq.size() != 0));
    if (txq.size() != 0) check({tag, " R1 txData"}, 32'(txData), 32'(txq[0]));
    check({tag, " R9 irq"}, 32'(irqOut),
          32'((rxq.size() != 0) || mOvr || mPar || mFrm));
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 8'h00, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic wrReg(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(1, 0, a, d, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rdReg(input logic [7:0] a, input string tag);
    cyc(0, 1, a, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic rxPush(input logic [7:0] b, input bit pe, input bit fe, input string tag);
    cyc(0, 0, 8'h00, 0, 1, b, pe, fe, 0, tag);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    #1;
    // reset state
    check("R12 reset status", 32'h20101000, modelStatus());
    rdReg(8'h9C, "R12 status after reset");
    check("R12 txValid", 32'(txValid), 32'(0));

    // byte writes then burst write, in-order drain
    wrReg(8'h00, 32'hFFFF_FF11, "R1 byte write");
    wrReg(8'h00, 32'h0000_0022, "R1 byte write");
    wrReg(8'hA0, 32'h66554433, "R3 burst write");
    rdReg(8'h9C, "R5 tx free after 6");
    for (int i = 0; i < 7; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R3 drain order");
    rdReg(8'h9C, "R10 tx empty bit");

    // fill transmit queue, short burst and full byte write
    for (int i = 0; i < 3; i++) wrReg(8'hA0, 32'hA3A2A1A0 + i, "R3 fill");
    wrReg(8'h00, 32'h000000B0, "R1 fill");
    wrReg(8'h00, 32'h000000B1, "R1 fill");
    wrReg(8'hA0, 32'hC3C2C1C0, "R6 short burst write");
    rdReg(8'h9C, "R6 status after short write");
    wrReg(8'h00, 32'h000000DD, "R11 byte write when full");
    rdReg(8'h9C, "R11 queue unchanged");
    wrReg(8'h02, 32'h00000042, "R7 wrong code no clear");
    rdReg(8'h9C, "R7 error still set");
    wrReg(8'h02, 32'h00000043, "R7 clear code");
    rdReg(8'h9C, "R7 error cleared");
    for (int i = 0; i < 17; i++) cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, "R1 drain full");

    // receive: byte reads and burst reads
    rdReg(8'h00, "R11 byte read empty");
    for (int i = 0; i < 6; i++) rxPush(8'h10 + 8'(i), 0, 0, "R2 rx push");
    rdReg(8'h9C, "R5 rx count");
    rdReg(8'h00, "R2 byte read");
    rdReg(8'hA4, "R4 burst read");
    rdReg(8'hA4, "R6 short burst read");
    rdReg(8'hA4, "R6 burst read empty");
    wrReg(8'h02, 32'h43, "R7 clear");

    // overrun
    for (int i = 0; i < 17; i++) rxPush(8'h40 + 8'(i), 0, 0, "R7 fill rx");
    rdReg(8'h9C, "R7 overrun set");
    cyc(0, 1, 8'hA4, 0, 1, 8'h77, 0, 0, 0, "R7 pop and push at full");
    rdReg(8'h9C, "R10 status after mixed");
    for (int i = 0; i < 4; i++) rdReg(8'hA4, "R4 drain rx");
    rdReg(8'h9C, "R7 overrun still set");
    wrReg(8'h02, 32'h43, "R7 clear overrun");
    rdReg(8'h9C, "R9 no pending");

    // parity and framing flags
    rxPush(8'h55, 1, 0, "R8 parity byte");
    rxPush(8'h66, 0, 1, "R8 frame byte");
    rdReg(8'h00, "R2 read");
    rdReg(8'h00, "R2 read");
    rdReg(8'h9C, "R8 flags set");
    rdReg(8'h9C, "R8 flags cleared");
    cyc(0, 1, 8'h9C, 0, 1, 8'h99, 1, 1, 0, "R8 set wins over clear");
    rdReg(8'h9C, "R8 flags after set");
    rdReg(8'h00, "R2 final read");
    rdReg(8'h9C, "R9 idle status");
    idle("R12 idle");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule